// File: doc/BRIEF.md
# I2C Write-Only Bus Master

This block is a single-master I2C transmitter. Software picks a target address and whether that target uses a 7-bit or a 10-bit address. It queues data bytes one at a time in a single holding register and raises control bits to open and close transactions. The controller drives the open-drain SCL and SDA lines through active-high pull-down enables. It samples SDA in each acknowledge slot. A divider input sets the length of a quarter bit.

A transaction opens with a START condition. The controller then sends one address header byte for a 7-bit target, or two for a 10-bit target. Queued data bytes follow back to back. The holding register empties at the first bit of the byte it held, so software can refill it while that byte is on the wire. When the register is empty and no command is pending, the controller parks with SCL low until something arrives. If the slave answers a byte with a not-acknowledge, the controller:
- raises a flag,
- drops any queued byte,
- holds SCL low until software asks for STOP or for a new START, which goes out as a repeated START.

The sequencer has these states:
- IDLE: bus released.
- START: four quarter-bit phases with SDA falling while SCL is high.
- BIT: eight data bit slots.
- ACK: the ninth clock, in which SDA is sampled.
- HOLD: SCL low, waiting for data or a command.
- HALT: SCL low after a not-acknowledge.
- STOP: SDA rising while SCL is high.

The transitions are:
- IDLE→START on a start request.
- START→BIT after its fourth phase.
- BIT→BIT between bits, and BIT→ACK after the eighth bit.
- ACK→HALT on a not-acknowledge.
- On an acknowledge, ACK→BIT when a second header byte or a queued byte is ready. Otherwise ACK→STOP on a stop request, ACK→START on a start request, or ACK→HOLD.
- HOLD leaves for BIT, STOP or START under the same priority as ACK.
- HALT→STOP or HALT→START, with STOP winning.
- STOP→IDLE.

Top module: `i2cw_master`

## Requirements
- R1: After reset both pull-down enables are 0, busy is 0, the register-empty flag is 1 and the not-acknowledge flag is 0.
- R2: SDA changes while SCL is released only inside a START (falling) or a STOP (rising). Every data and acknowledge level is set up while SCL is low.
- R3: For a 7-bit target the first byte after START is {addr[6:0], 0}. All bytes are sent MSB first, each followed by a ninth acknowledge clock.
- R4: When `addr_10b` is 1 at the moment START is taken, the first byte is {11110, addr[9:8], 0} and the second is addr[7:0]. The choice is made per transaction.
- R5: Queued bytes follow the header in write order with no extra conditions between them. The empty flag rises when a held byte begins to shift out. `tx_irq` equals the empty flag ANDed with `tx_ie`.
- R6: The acknowledge level is read at the rising edge of the ninth SCL clock. Low means acknowledge; high means not-acknowledge.
- R7: A stop request is served after the byte on the wire completes. After STOP both request bits read 0 and busy falls.
- R8: A byte held in the register when STOP is requested is still sent before the STOP condition.
- R9: On a not-acknowledge the flag sets, `nack_irq` follows it when `nack_ie` is 1, and SCL stays pulled low with busy high until a command arrives. `nack_clr` clears the flag.
- R10: A not-acknowledge empties the holding register. A byte queued before it is never transmitted.
- R11: From the halted or parked state, a start request produces a repeated START and a fresh header. A stop request produces a STOP.
- R12: A flush pulse empties the holding register, and the flushed byte never reaches the bus.
- R13: Each quarter-bit phase lasts `div`+1 clocks, so one SCL period is 4·(`div`+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div | input | DIV_W | Quarter-bit length minus one, in clocks |
| tgt_addr | input | 10 | Target address; bits [6:0] used in 7-bit mode |
| addr_10b | input | 1 | 1 selects 10-bit header for the next START |
| start_set | input | 1 | Pulse: request START or repeated START |
| stop_set | input | 1 | Pulse: request STOP |
| flush_set | input | 1 | Pulse: discard the held byte |
| tx_ie | input | 1 | Enable for the empty interrupt |
| nack_ie | input | 1 | Enable for the not-acknowledge interrupt |
| nack_clr | input | 1 | Pulse: clear the not-acknowledge flag |
| tx_wr | input | 1 | Pulse: write `tx_data` into the holding register |
| tx_data | input | 8 | Byte to queue |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Transaction in progress |
| start_pend | output | 1 | Start request bit (self-clearing) |
| stop_pend | output | 1 | Stop request bit (self-clearing) |
| tx_empty | output | 1 | Holding register empty |
| tx_irq | output | 1 | Empty interrupt |
| nack_flag | output | 1 | Not-acknowledge flag |
| nack_irq | output | 1 | Not-acknowledge interrupt |

## Verification
At a byte boundary, a pending stop request can meet a byte still held in the register. The bench sets STOP right after writing the last byte, while that byte is still queued. It then decodes the bus and requires the byte before the STOP condition. A not-acknowledge can likewise meet a queued byte. The bench queues a byte, lets the slave refuse the byte being sent, and requires the register to read empty while halted and the queued byte to be absent from the bus log.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam int BIT_CW = $clog2(BYTE_W);
    localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_ACK,
        ST_HOLD,
        ST_HALT,
        ST_STOP
    } seq_state_t;

    typedef logic [1:0] phase_t;
    localparam phase_t PH_LOW_A  = 2'd0;
    localparam phase_t PH_LOW_B  = 2'd1;
    localparam phase_t PH_HIGH_A = 2'd2;
    localparam phase_t PH_HIGH_B = 2'd3;
endpackage

// File: rtl/i2cw_clkdiv.sv
module i2cw_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R13
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/i2cw_txbuf.sv
module i2cw_txbuf
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              flush,
    input  logic              take,
    output logic              full,
    output logic [BYTE_W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (flush) begin
            full <= 1'b0;
        end else if (wr) begin
            full <= 1'b1;
            data <= wdata;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cw_seq.sv
module i2cw_seq
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              addr_10b,
    input  logic              start_set,
    input  logic              stop_set,
    input  logic              nack_clr,
    input  logic              sda_in,
    input  logic              buf_full,
    input  logic [BYTE_W-1:0] buf_data,
    output logic              buf_take,
    output logic              buf_drop,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              start_pend,
    output logic              stop_pend,
    output logic              nack_flag
);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    seq_state_t        st_q, st_d;
    phase_t            ph_q, ph_d;
    logic [BIT_CW-1:0] bit_q, bit_d;
    logic [BYTE_W-1:0] sh_q, sh_d;
    logic [BYTE_W-1:0] h2_q, h2_d;
    logic              h2p_q, h2p_d;
    logic              ackbad_q, ackbad_d;
    logic              start_q, stop_q, nack_q;
    logic              scl_q, sda_q;
    logic              sclr, pclr, nset, decide, go_start;
    logic [BYTE_W-1:0] hdr_first;

    assign hdr_first = addr_10b ? {TEN_BIT_PREFIX, tgt_addr[9:8], 1'b0}
                                : {tgt_addr[6:0], 1'b0};

    always_comb begin
        st_d     = st_q;
        ph_d     = ph_q;
        bit_d    = bit_q;
        sh_d     = sh_q;
        h2_d     = h2_q;
        h2p_d    = h2p_q;
        ackbad_d = ackbad_q;
        buf_take = 1'b0;
        buf_drop = 1'b0;
        sclr     = 1'b0;
        pclr     = 1'b0;
        nset     = 1'b0;
        decide   = 1'b0;
        go_start = 1'b0;
        if (tick) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_q) begin
                        go_start = 1'b1;
                    end else if (stop_q) begin
                        pclr = 1'b1;
                    end
                end
                ST_START: begin
                    ph_d = ph_q + 2'd1;
                    if (ph_q == PH_HIGH_B) begin
                        st_d  = ST_BIT;
                        bit_d = '0;
                    end
                end
                ST_BIT: begin
                    ph_d = ph_q + 2'd1;
                    if (ph_q == PH_HIGH_B) begin
                        if (bit_q == LAST_BIT) begin
                            st_d = ST_ACK;
                        end else begin
                            bit_d = bit_q + 1'b1;
                            sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_ACK: begin
                    ph_d = ph_q + 2'd1;
                    if (ph_q == PH_LOW_B) begin
                        ackbad_d = sda_in;
                    end
                    if (ph_q == PH_HIGH_B) begin
                        ph_d = PH_LOW_A;
                        if (ackbad_q) begin
                            nset     = 1'b1;
                            buf_drop = 1'b1;
                            h2p_d    = 1'b0;
                            st_d     = ST_HALT;
                        end else begin
                            decide = 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    decide = 1'b1;
                end
                ST_HALT: begin
                    if (stop_q) begin
                        st_d = ST_STOP;
                        ph_d = PH_LOW_A;
                    end else if (start_q) begin
                        go_start = 1'b1;
                    end
                end
                ST_STOP: begin
                    ph_d = ph_q + 2'd1;
                    if (ph_q == PH_HIGH_B) begin
                        st_d = ST_IDLE;
                        pclr = 1'b1;
                        sclr = 1'b1;
                    end
                end
                default: begin
                    st_d = ST_IDLE;
                    ph_d = PH_LOW_A;
                end
            endcase
        end

        if (decide) begin
            ph_d  = PH_LOW_A;
            bit_d = '0;
            if (h2p_q) begin
                sh_d  = h2_q;
                h2p_d = 1'b0;
                st_d  = ST_BIT;
            end else if (buf_full) begin
                sh_d     = buf_data;
                buf_take = 1'b1;
                st_d     = ST_BIT;
            end else if (stop_q) begin
                st_d = ST_STOP;
            end else if (start_q) begin
                go_start = 1'b1;
            end else begin
                st_d = ST_HOLD;
            end
        end

        if (go_start) begin
            st_d  = ST_START;
            ph_d  = PH_LOW_A;
            sclr  = 1'b1;
            sh_d  = hdr_first;
            h2_d  = tgt_addr[7:0];
            h2p_d = addr_10b;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            ph_q     <= PH_LOW_A;
            bit_q    <= '0;
            sh_q     <= '0;
            h2_q     <= '0;
            h2p_q    <= 1'b0;
            ackbad_q <= 1'b0;
            start_q  <= 1'b0;
            stop_q   <= 1'b0;
            nack_q   <= 1'b0;
        end else begin
            st_q     <= st_d;
            ph_q     <= ph_d;
            bit_q    <= bit_d;
            sh_q     <= sh_d;
            h2_q     <= h2_d;
            h2p_q    <= h2p_d;
            ackbad_q <= ackbad_d;
            start_q  <= start_set | (start_q & ~sclr);
            stop_q   <= stop_set | (stop_q & ~pclr);
            nack_q   <= nset | (nack_q & ~nack_clr);
        end
    end

    // bus outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b0;
            sda_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    scl_q <= 1'b0;
                    sda_q <= 1'b0;
                end
                ST_START: begin
                    scl_q <= (ph_q == PH_LOW_A);
                    sda_q <= ph_q[1];
                end
                ST_BIT: begin
                    scl_q <= ~ph_q[1];
                    if (ph_q != PH_LOW_A) sda_q <= ~sh_q[BYTE_W-1];
                end
                ST_ACK: begin
                    scl_q <= ~ph_q[1];
                    if (ph_q != PH_LOW_A) sda_q <= 1'b0;
                end
                ST_HOLD, ST_HALT: begin
                    scl_q <= 1'b1;
                end
                ST_STOP: begin
                    scl_q <= ~ph_q[1];
                    if (ph_q == PH_LOW_B || ph_q == PH_HIGH_A) sda_q <= 1'b1;
                    else if (ph_q == PH_HIGH_B) sda_q <= 1'b0;
                end
                default: begin
                    scl_q <= 1'b0;
                    sda_q <= 1'b0;
                end
            endcase
        end
    end

    assign scl_oe     = scl_q;
    assign sda_oe     = sda_q;
    assign busy       = (st_q != ST_IDLE);
    assign start_pend = start_q;
    assign stop_pend  = stop_q;
    assign nack_flag  = nack_q;

    // R2
    sda_edge_only_in_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_q && !$past(scl_q) && (sda_q != $past(sda_q)))
        |-> ($past(st_q) == ST_START || $past(st_q) == ST_STOP));

    // R9
    halt_holds_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT && $past(st_q) == ST_HALT) |-> scl_q);

    // R10
    nack_empties_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_ACK && st_q == ST_HALT) |-> (!buf_full && nack_q));

    // R7
    stop_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_STOP && st_q == ST_IDLE && !$past(stop_set)) |-> !stop_q);

    // R1
    idle_releases_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |-> (!scl_q && !sda_q));
endmodule

// File: rtl/i2cw_master.sv
module i2cw_master
    import i2cw_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              addr_10b,
    input  logic              start_set,
    input  logic              stop_set,
    input  logic              flush_set,
    input  logic              tx_ie,
    input  logic              nack_ie,
    input  logic              nack_clr,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              start_pend,
    output logic              stop_pend,
    output logic              tx_empty,
    output logic              tx_irq,
    output logic              nack_flag,
    output logic              nack_irq
);
    logic              tick;
    logic              buf_full, buf_take, buf_drop;
    logic [BYTE_W-1:0] buf_data;

    i2cw_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (div),
        .tick  (tick)
    );

    i2cw_txbuf u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (tx_wr),
        .wdata (tx_data),
        .flush (flush_set | buf_drop),
        .take  (buf_take),
        .full  (buf_full),
        .data  (buf_data)
    );

    i2cw_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .tgt_addr   (tgt_addr),
        .addr_10b   (addr_10b),
        .start_set  (start_set),
        .stop_set   (stop_set),
        .nack_clr   (nack_clr),
        .sda_in     (sda_in),
        .buf_full   (buf_full),
        .buf_data   (buf_data),
        .buf_take   (buf_take),
        .buf_drop   (buf_drop),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .busy       (busy),
        .start_pend (start_pend),
        .stop_pend  (stop_pend),
        .nack_flag  (nack_flag)
    );

    assign tx_empty = ~buf_full;
    assign tx_irq   = tx_ie & ~buf_full;
    assign nack_irq = nack_ie & nack_flag;
endmodule

// File: tb/i2cw_master_test.sv
module i2cw_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int EV_S = 'h100;
    localparam int EV_P = 'h200;
    localparam int EV_NK = 'h400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div = 8'd1;
    logic [9:0] tgt_addr = '0;
    logic       addr_10b = 1'b0;
    logic       start_set = 1'b0, stop_set = 1'b0, flush_set = 1'b0;
    logic       tx_ie = 1'b0, nack_ie = 1'b0, nack_clr = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       scl_oe, sda_oe, busy, start_pend, stop_pend;
    logic       tx_empty, tx_irq, nack_flag, nack_irq;
    logic       slv_pull = 1'b0;
    logic       scl_w, sda_w;

    int errors = 0;
    int checks = 0;

    assign scl_w = ~scl_oe;
    assign sda_w = ~(sda_oe | slv_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cw_master #(.DIV_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .div(div), .tgt_addr(tgt_addr),
        .addr_10b(addr_10b), .start_set(start_set), .stop_set(stop_set),
        .flush_set(flush_set), .tx_ie(tx_ie), .nack_ie(nack_ie),
        .nack_clr(nack_clr), .tx_wr(tx_wr), .tx_data(tx_data), .sda_in(sda_w),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .start_pend(start_pend),
        .stop_pend(stop_pend), .tx_empty(tx_empty), .tx_irq(tx_irq),
        .nack_flag(nack_flag), .nack_irq(nack_irq)
    );

    // bus monitor and slave model
    int   ev [0:63];
    int   nev = 0;
    int   bcnt = 0;
    int   bidx = 0;
    int   nack_at = -1;
    logic [7:0] shb = '0;
    logic scl_p = 1'b1, sda_p = 1'b1;
    longint t_rise = 0, last_int = 0;

    function automatic void push(int v);
        if (nev < 64) ev[nev] = v;
        nev++;
    endfunction

    always @(scl_w or sda_w) begin
        if (scl_w === scl_p) begin
            if (scl_w === 1'b1 && sda_p === 1'b1 && sda_w === 1'b0) begin
                push(EV_S); bcnt = 0; bidx = 0;
            end else if (scl_w === 1'b1 && sda_p === 1'b0 && sda_w === 1'b1) begin
                push(EV_P); bcnt = 0;
            end
        end else if (scl_w === 1'b1) begin
            if (bcnt >= 1 && bcnt <= 7) last_int = longint'($time) - t_rise;
            t_rise = longint'($time);
            if (bcnt < 8) begin
                shb = {shb[6:0], sda_w};
                bcnt++;
            end else begin
                push(int'(shb) | (sda_w ? EV_NK : 0));
                bcnt = 0;
                bidx++;
            end
        end else if (scl_w === 1'b0) begin
            slv_pull = (bcnt == 8) && (bidx != nack_at);
        end
        scl_p = scl_w;
        sda_p = sda_w;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_set = 1'b1;
        @(negedge clk) start_set = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_set = 1'b1;
        @(negedge clk) stop_set = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk) begin tx_wr = 1'b1; tx_data = b; end
        @(negedge clk) tx_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (!busy && !start_pend && !stop_pend) break;
        end
    endtask

    function automatic logic [7:0] dbyte(input logic [9:0] a, input int k);
        return 8'((int'(a) * 13 + k * 37 + 5) & 255);
    endfunction

    // one write transaction, with optional slave refusal at byte index nk
    task automatic run_txn(input logic [9:0] a, input bit ten, input int n,
                           input int nk, input string req);
        int ex [0:31];
        int bl [0:15];
        int ne = 0, nb = 0, sent = 0;
        bit stopped = 0, refused = 0;
        if (ten) begin
            bl[0] = int'({5'b11110, a[9:8], 1'b0});
            bl[1] = int'(a[7:0]);
            nb = 2;
        end else begin
            bl[0] = int'({a[6:0], 1'b0});
            nb = 1;
        end
        for (int k = 0; k < n; k++) begin bl[nb] = int'(dbyte(a, k)); nb++; end
        ex[ne++] = EV_S;
        for (int i = 0; i < nb; i++) begin
            if (i == nk) begin ex[ne++] = bl[i] | EV_NK; break; end
            ex[ne++] = bl[i];
        end
        ex[ne++] = EV_P;

        nack_at = nk;
        nev = 0;
        tgt_addr = a;
        addr_10b = ten;
        if (n > 0) begin write_byte(dbyte(a, 0)); sent = 1; end
        pulse_start();
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (nack_flag) begin refused = 1; break; end
            if (!busy && !start_pend && !stop_pend) break;
            if (sent < n && tx_empty) begin
                write_byte(dbyte(a, sent)); sent++;
            end else if (sent == n && !stopped) begin
                pulse_stop(); stopped = 1;
            end
        end
        if (refused) begin
            repeat (24) @(negedge clk);
            chk(scl_oe === 1'b1 && busy === 1'b1, {req, " R9 halt"}, {scl_oe, busy}, 3);
            chk(nack_irq === nack_ie, "R9 irq", nack_irq, nack_ie);
            chk(tx_empty === 1'b1, "R10 queued byte dropped", tx_empty, 1);
            pulse_stop();
            wait_idle();
            @(negedge clk) nack_clr = 1'b1;
            @(negedge clk) nack_clr = 1'b0;
            chk(nack_flag === 1'b0, "R9 clear", nack_flag, 0);
        end
        repeat (4) @(negedge clk);
        chk(nev == ne, {req, " event count"}, nev, ne);
        for (int i = 0; i < ne && i < nev; i++)
            chk(ev[i] == ex[i], {req, " bus event"}, ev[i], ex[i]);
        chk(!busy && !start_pend && !stop_pend, "R7 end state",
            {busy, start_pend, stop_pend}, 0);
        nack_at = -1;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [9:0] a7 [0:3];
        logic [9:0] a10 [0:3];
        a7[0] = 10'h000; a7[1] = 10'h02A; a7[2] = 10'h055; a7[3] = 10'h07F;
        a10[0] = 10'h000; a10[1] = 10'h155; a10[2] = 10'h2AA; a10[3] = 10'h3FF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1
        chk(scl_oe === 1'b0 && sda_oe === 1'b0, "R1 bus", {scl_oe, sda_oe}, 0);
        chk(busy === 1'b0 && tx_empty === 1'b1 && nack_flag === 1'b0, "R1 flags",
            {busy, tx_empty, nack_flag}, 2);

        // R5 interrupt gating and R12 flush
        tx_ie = 1'b1;
        @(negedge clk);
        chk(tx_irq === 1'b1, "R5 irq empty", tx_irq, 1);
        write_byte(8'hA5);
        chk(tx_empty === 1'b0 && tx_irq === 1'b0, "R5 irq full", {tx_empty, tx_irq}, 0);
        @(negedge clk) flush_set = 1'b1;
        @(negedge clk) flush_set = 1'b0;
        chk(tx_empty === 1'b1, "R12 flush empties", tx_empty, 1);
        tx_ie = 1'b0;
        @(negedge clk);
        chk(tx_irq === 1'b0, "R5 irq disabled", tx_irq, 0);
        run_txn(10'h033, 1'b0, 0, -1, "R12 flushed byte absent");

        // R3 R5 R8: 7-bit sweep
        for (int i = 0; i < 4; i++)
            for (int n = 0; n < 4; n += 1)
                if (n != 2) run_txn(a7[i], 1'b0, n, -1, "R3 R5 R8");

        // R4: 10-bit sweep
        for (int i = 0; i < 4; i++) begin
            run_txn(a10[i], 1'b1, 0, -1, "R4");
            run_txn(a10[i], 1'b1, 2, -1, "R4 R8");
        end

        // R6 R9 R10: refusal at several byte positions
        nack_ie = 1'b1;
        run_txn(10'h051, 1'b0, 3, 0, "R6 address refused");
        run_txn(10'h051, 1'b0, 3, 1, "R6 data refused");
        nack_ie = 1'b0;
        run_txn(10'h2C3, 1'b1, 3, 1, "R6 second header refused");
        run_txn(10'h2C3, 1'b1, 3, 2, "R6 ten-bit data refused");

        // R11: repeated start after halt, then park and stop
        begin
            int ex [0:7];
            nev = 0;
            nack_at = 0;
            tgt_addr = 10'h012; addr_10b = 1'b0;
            pulse_start();
            for (int c = 0; c < 5000 && !nack_flag; c++) @(negedge clk);
            nack_at = -1;
            @(negedge clk) nack_clr = 1'b1;
            @(negedge clk) nack_clr = 1'b0;
            tgt_addr = 10'h1E7; addr_10b = 1'b1;
            pulse_start();
            for (int c = 0; c < 5000 && nev < 5; c++) @(negedge clk);
            repeat (40) @(negedge clk);
            chk(scl_oe === 1'b1 && busy === 1'b1, "R11 parked", {scl_oe, busy}, 3);
            pulse_stop();
            wait_idle();
            repeat (4) @(negedge clk);
            ex[0] = EV_S; ex[1] = 'h24 | EV_NK; ex[2] = EV_S;
            ex[3] = int'({5'b11110, 2'b01, 1'b0}); ex[4] = 'hE7; ex[5] = EV_P;
            chk(nev == 6, "R11 event count", nev, 6);
            for (int i = 0; i < 6 && i < nev; i++)
                chk(ev[i] == ex[i], "R11 bus event", ev[i], ex[i]);
        end

        // R13: SCL period versus divider
        div = 8'd3;
        repeat (8) @(negedge clk);
        run_txn(10'h06C, 1'b0, 1, -1, "R3 R13");
        chk(last_int == longint'(4 * 4 * CLK_PERIOD), "R13 period div3",
            int'(last_int), 4 * 4 * CLK_PERIOD);
        div = 8'd1;
        repeat (8) @(negedge clk);
        run_txn(10'h06C, 1'b0, 1, -1, "R3 R13");
        chk(last_int == longint'(4 * 2 * CLK_PERIOD), "R13 period div1",
            int'(last_int), 4 * 2 * CLK_PERIOD);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule